// File: doc/BRIEF.md
# CAN Standard Data Frame Transmitter

This block turns one standard-format CAN data frame into a serial bit stream on a single transmit line, where 0 is the dominant level and 1 the recessive level. A frame request carries an 11-bit identifier, a remote-request flag, a 4-bit length code and up to eight data bytes. The block then advances by one bit on every bit-time strobe from an external bit-timing unit, and builds the 15-bit CRC from the bits as they leave.

The block reads the sampled bus level back at every strobe. If it sends recessive in the arbitration bits and the bus reads dominant, it has lost arbitration to a node with a lower identifier. It then withdraws at once and reports the loss. In the acknowledge slot it sends recessive and expects a receiver to pull the bus dominant. If none does, the block reports an acknowledge error along with frame completion. Bit stuffing, error frames and retransmission belong to other blocks.

Top module: `can_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx` is 1 (recessive) and `busy` is 0.
- R2: A pulse on `start` is taken only while `busy` is 0. The identifier, flag, length and data are latched in that cycle. `start` and changes to the frame inputs during a frame leave the frame being sent unchanged.
- R3: The frame sent is, in this order: one 0 (start bit), the identifier MSB first, `rtr`, a 0 (format bit), a 0 (reserved bit), the length code MSB first, then the data bytes. Byte 0 is `data[63:56]` and goes first, and each byte goes MSB first.
- R4: Next come 15 CRC bits, MSB first. The CRC register starts at zero and shifts through every bit from the start bit to the last data bit, using generator x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 (feedback mask 0x4599).
- R5: After the CRC, the block sends ten 1 bits: the CRC delimiter, the acknowledge slot, the acknowledge delimiter and seven end bits.
- R6: `tx` changes only in the clock cycle after a cycle with `bit_tick` high. Each strobe ends the current bit, and `rx` is sampled in that strobe cycle.
- R7: Suppose `tx` is 1 during an identifier bit or the `rtr` bit, and `rx` is 0 at that bit's strobe. Then `arb_lost` pulses for one cycle in the next cycle, `tx` returns to 1, `busy` drops and `done` is not raised.
- R8: If `rx` is 1 at the strobe that ends the acknowledge slot, `ack_error` pulses together with `done`. Otherwise `ack_error` stays 0.
- R9: The cycle after the strobe that ends the seventh end bit, `done` pulses for one cycle and `busy` drops. A frame with N data bytes takes 44 + 8·N strobes.
- R10: A length code above 8 is sent as given, but only 8 data bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at the end of each bit time |
| start | input | 1 | Frame request, taken while idle |
| id_in | input | 11 | Identifier |
| rtr_in | input | 1 | Remote-request flag |
| dlc_in | input | 4 | Length code |
| data_in | input | 64 | Data, byte 0 in bits 63:56 |
| rx | input | 1 | Sampled bus level |
| tx | output | 1 | Transmit level, 1 = recessive |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished pulse |
| arb_lost | output | 1 | Arbitration lost pulse |
| ack_error | output | 1 | No acknowledge, pulses with done |

## Verification
Random identifiers, flags, length codes 0 to 15 and data give frames whose full bit streams, CRC included, are compared with a separately built model. A wrong bit order, field order, CRC feedback term or byte count shows up there. Directed frames cover the edge cases. Length 0 and all-ones data test the data-to-CRC handover and the CRC at its extremes. A length code of 12 separates the code sent on the line from the byte count used. Arbitration is lost once in the identifier and once on the remote-request bit, which tests the window limits. A frame with no acknowledge, and a frame hit by `start` and changed inputs mid-frame, test the acknowledge check and input latching.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SOF,
    ST_ID,
    ST_RTR,
    ST_IDE,
    ST_R0,
    ST_DLC,
    ST_DATA,
    ST_CRC,
    ST_CRC_DEL,
    ST_ACK,
    ST_ACK_DEL,
    ST_EOF
  } tx_state_e;

endpackage

// File: rtl/can_crc_shift.sv
module can_crc_shift #(
  parameter int               W    = 15,
  parameter logic [W-1:0]     POLY = 15'h4599
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ din;
    crc_d = crc_q;
    if (clear) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/can_bit_select.sv
module can_bit_select
  import can_tx_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int CRC_W  = 15,
  parameter int CNT_W  = 6
) (
  input  tx_state_e          state,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [ID_W-1:0]    id,
  input  logic               rtr,
  input  logic [DLC_W-1:0]   dlc,
  input  logic [DATA_W-1:0]  data,
  input  logic [CRC_W-1:0]   crc,
  output logic               bit_out
);

  logic [ID_W-1:0]   id_sh;
  logic [DLC_W-1:0]  dlc_sh;
  logic [DATA_W-1:0] data_sh;
  logic [CRC_W-1:0]  crc_sh;

  always_comb begin
    id_sh   = id   >> (ID_W   - 1 - int'(cnt));
    dlc_sh  = dlc  >> (DLC_W  - 1 - int'(cnt));
    data_sh = data >> (DATA_W - 1 - int'(cnt));
    crc_sh  = crc  >> (CRC_W  - 1 - int'(cnt));
    unique case (state)
      ST_SOF:  bit_out = 1'b0;
      ST_ID:   bit_out = id_sh[0];
      ST_RTR:  bit_out = rtr;
      ST_IDE:  bit_out = 1'b0;
      ST_R0:   bit_out = 1'b0;
      ST_DLC:  bit_out = dlc_sh[0];
      ST_DATA: bit_out = data_sh[0];
      ST_CRC:  bit_out = crc_sh[0];
      default: bit_out = 1'b1;
    endcase
  end

endmodule

// File: rtl/can_bus_monitor.sv
module can_bus_monitor
  import can_tx_pkg::*;
(
  input  tx_state_e state,
  input  logic      bit_out,
  input  logic      rx,
  output logic      lost,
  output logic      ack_absent
);

  logic arb_window;

  assign arb_window = (state == ST_ID) || (state == ST_RTR);
  assign lost       = arb_window && bit_out && !rx;
  assign ack_absent = (state == ST_ACK) && rx;

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int              ID_W      = 11,
  parameter int              DLC_W     = 4,
  parameter int              MAX_BYTES = 8,
  parameter int              CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599,
  parameter int              EOF_LEN   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic                   start,
  input  logic [ID_W-1:0]        id_in,
  input  logic                   rtr_in,
  input  logic [DLC_W-1:0]       dlc_in,
  input  logic [8*MAX_BYTES-1:0] data_in,
  input  logic                   rx,
  output logic                   tx,
  output logic                   busy,
  output logic                   done,
  output logic                   arb_lost,
  output logic                   ack_error
);

  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int NB_W   = $clog2(MAX_BYTES + 1);

  tx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ID_W-1:0]    id_q;
  logic               rtr_q;
  logic [DLC_W-1:0]   dlc_q;
  logic [DATA_W-1:0]  data_q;
  logic [NB_W-1:0]    nbytes_q, nbytes_in;
  logic               ack_miss_q, ack_miss_d;
  logic               done_q, done_d;
  logic               arb_q, arb_d;
  logic               ackerr_q, ackerr_d;
  logic               load;
  logic               cur_bit;
  logic               lost_now;
  logic               ack_absent;
  logic               crc_en;
  logic [CRC_W-1:0]   crc;
  logic [CNT_W-1:0]   data_last;

  assign nbytes_in = (dlc_in > DLC_W'(MAX_BYTES)) ? NB_W'(MAX_BYTES) : NB_W'(dlc_in);
  assign data_last = CNT_W'(int'(nbytes_q) * 8 - 1);

  can_bit_select #(
    .ID_W  (ID_W),
    .DLC_W (DLC_W),
    .DATA_W(DATA_W),
    .CRC_W (CRC_W),
    .CNT_W (CNT_W)
  ) u_sel (
    .state  (state_q),
    .cnt    (cnt_q),
    .id     (id_q),
    .rtr    (rtr_q),
    .dlc    (dlc_q),
    .data   (data_q),
    .crc    (crc),
    .bit_out(cur_bit)
  );

  can_bus_monitor u_mon (
    .state     (state_q),
    .bit_out   (cur_bit),
    .rx        (rx),
    .lost      (lost_now),
    .ack_absent(ack_absent)
  );

  assign crc_en = bit_tick && !lost_now &&
                  (state_q inside {ST_SOF, ST_ID, ST_RTR, ST_IDE, ST_R0, ST_DLC, ST_DATA});

  can_crc_shift #(
    .W   (CRC_W),
    .POLY(CRC_POLY)
  ) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(load),
    .en   (crc_en),
    .din  (cur_bit),
    .crc  (crc)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    ack_miss_d = ack_miss_q;
    done_d     = 1'b0;
    arb_d      = 1'b0;
    ackerr_d   = 1'b0;
    load       = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start) begin
        load       = 1'b1;
        state_d    = ST_SOF;
        cnt_d      = '0;
        ack_miss_d = 1'b0;
      end
    end else if (bit_tick) begin
      if (lost_now) begin
        state_d = ST_IDLE;
        arb_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        unique case (state_q)
          ST_SOF: begin
            state_d = ST_ID;
            cnt_d   = '0;
          end
          ST_ID: if (cnt_q == CNT_W'(ID_W - 1)) begin
            state_d = ST_RTR;
            cnt_d   = '0;
          end
          ST_RTR: state_d = ST_IDE;
          ST_IDE: state_d = ST_R0;
          ST_R0: begin
            state_d = ST_DLC;
            cnt_d   = '0;
          end
          ST_DLC: if (cnt_q == CNT_W'(DLC_W - 1)) begin
            state_d = (nbytes_q == '0) ? ST_CRC : ST_DATA;
            cnt_d   = '0;
          end
          ST_DATA: if (cnt_q == data_last) begin
            state_d = ST_CRC;
            cnt_d   = '0;
          end
          ST_CRC: if (cnt_q == CNT_W'(CRC_W - 1)) begin
            state_d = ST_CRC_DEL;
          end
          ST_CRC_DEL: state_d = ST_ACK;
          ST_ACK: begin
            state_d    = ST_ACK_DEL;
            ack_miss_d = ack_absent;
          end
          ST_ACK_DEL: begin
            state_d = ST_EOF;
            cnt_d   = '0;
          end
          ST_EOF: if (cnt_q == CNT_W'(EOF_LEN - 1)) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            ackerr_d = ack_miss_q;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  // state and flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      ack_miss_q <= 1'b0;
      done_q     <= 1'b0;
      arb_q      <= 1'b0;
      ackerr_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      ack_miss_q <= ack_miss_d;
      done_q     <= done_d;
      arb_q      <= arb_d;
      ackerr_q   <= ackerr_d;
    end
  end

  // frame content registers, enabled by load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      rtr_q    <= 1'b0;
      dlc_q    <= '0;
      data_q   <= '0;
      nbytes_q <= '0;
    end else if (load) begin
      id_q     <= id_in;
      rtr_q    <= rtr_in;
      dlc_q    <= dlc_in;
      data_q   <= data_in;
      nbytes_q <= nbytes_in;
    end
  end

  assign tx        = cur_bit;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign arb_lost  = arb_q;
  assign ack_error = ackerr_q;

endmodule

// File: rtl/can_frame_tx_chk.sv
module can_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic start,
  input logic tx,
  input logic busy,
  input logic done,
  input logic arb_lost,
  input logic ack_error
);

  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !tx);

  // R6
  tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(bit_tick) |-> $stable(tx));

  // R7
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !busy && tx && !done);

  // R8
  ack_err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_error |-> done);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && tx);

endmodule

bind can_frame_tx can_frame_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .start    (start),
  .tx       (tx),
  .busy     (busy),
  .done     (done),
  .arb_lost (arb_lost),
  .ack_error(ack_error)
);

// File: tb/can_frame_tx_test.sv
`timescale 1ns/1ps
module can_frame_tx_test;

  logic        clk;
  logic        rst_n;
  logic        bit_tick;
  logic        start;
  logic [10:0] id_i;
  logic        rtr_i;
  logic [3:0]  dlc_i;
  logic [63:0] data_i;
  logic        ext_bus;
  logic        rx;
  logic        tx;
  logic        busy;
  logic        done;
  logic        arb_lost;
  logic        ack_error;

  int errors = 0;
  int checks = 0;

  logic        exp_bits [0:127];
  int          exp_len;
  int          ack_idx;
  int          data_end;

  can_frame_tx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .start    (start),
    .id_in    (id_i),
    .rtr_in   (rtr_i),
    .dlc_in   (dlc_i),
    .data_in  (data_i),
    .rx       (rx),
    .tx       (tx),
    .busy     (busy),
    .done     (done),
    .arb_lost (arb_lost),
    .ack_error(ack_error)
  );

  // wired-AND bus: other nodes pull dominant through ext_bus
  assign rx = tx & ext_bus;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
    logic [14:0] n;
    n = {c[13:0], 1'b0};
    if (c[14] ^ b) n = n ^ 15'h4599;
    return n;
  endfunction

  task automatic build_expected(input logic [10:0] id, input logic r,
                                input logic [3:0] d, input logic [63:0] data);
    int nb;
    int k;
    logic [14:0] c;
    nb = (d > 4'd8) ? 8 : int'(d);
    k = 0;
    exp_bits[k++] = 1'b0;
    for (int i = 10; i >= 0; i--) exp_bits[k++] = id[i];
    exp_bits[k++] = r;
    exp_bits[k++] = 1'b0;
    exp_bits[k++] = 1'b0;
    for (int i = 3; i >= 0; i--) exp_bits[k++] = d[i];
    for (int i = 0; i < nb * 8; i++) exp_bits[k++] = data[63 - i];
    data_end = k;
    c = '0;
    for (int i = 0; i < k; i++) c = crc_step(c, exp_bits[i]);
    for (int i = 14; i >= 0; i--) exp_bits[k++] = c[i];
    exp_bits[k++] = 1'b1;
    ack_idx = k;
    for (int i = 0; i < 9; i++) exp_bits[k++] = 1'b1;
    exp_len = k;
  endtask

  function automatic string region_req(input int idx, input logic [3:0] d);
    if (idx < data_end) return (d > 4'd8) ? "R3/R10" : "R3";
    if (idx < ack_idx - 1) return "R4";
    return "R5";
  endfunction

  task automatic run_frame(input logic [10:0] id, input logic r, input logic [3:0] d,
                           input logic [63:0] data, input bit give_ack,
                           input int lose_at, input bit poke);
    int   first_bad;
    logic got_bad;
    int   unstable;
    int   ticks;
    logic tx_after;
    build_expected(id, r, d, data);
    first_bad = -1;
    got_bad   = 1'b0;
    unstable  = 0;
    ticks     = 0;
    @(negedge clk);
    id_i = id; rtr_i = r; dlc_i = d; data_i = data;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < exp_len; i++) begin
      if (tx !== exp_bits[i] && first_bad < 0) begin
        first_bad = i;
        got_bad   = tx;
      end
      if (i == ack_idx && give_ack) ext_bus = 1'b0;
      if (i == lose_at) ext_bus = 1'b0;
      if (poke && i == 5) begin
        start = 1'b1;
        id_i = ~id; rtr_i = ~r; dlc_i = ~d; data_i = ~data;
      end
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      start    = 1'b0;
      ext_bus  = 1'b1;
      ticks++;
      if (i == lose_at) begin
        // R7
        check(arb_lost === 1'b1 && busy === 1'b0 && tx === 1'b1 && done === 1'b0,
              "R7", "arb loss response {arb,busy,tx,done}",
              {28'd0, arb_lost, busy, tx, done}, 32'hA);
        @(negedge clk);
        check(arb_lost === 1'b0 && tx === 1'b1, "R7", "arb pulse width/release",
              {30'd0, arb_lost, tx}, 32'h1);
        break;
      end
      if (i == exp_len - 1) begin
        // R9
        check(done === 1'b1 && busy === 1'b0, "R9", "done/busy after last bit",
              {30'd0, done, busy}, 32'h2);
        // R8
        check(ack_error === !give_ack, "R8", "ack_error with done",
              {31'd0, ack_error}, {31'd0, !give_ack});
        @(negedge clk);
        // R9
        check(done === 1'b0 && tx === 1'b1, "R9", "done one cycle, line idle",
              {30'd0, done, tx}, 32'h1);
      end else begin
        if (done === 1'b1) unstable++;
        tx_after = tx;
        @(negedge clk);
        if (tx !== tx_after) unstable++;
      end
    end
    if (first_bad >= 0)
      check(1'b0, region_req(first_bad, d), $sformatf("bit %0d of stream", first_bad),
            {31'd0, got_bad}, {31'd0, exp_bits[first_bad]});
    else
      check(1'b1, "R3", "stream", 0, 0);
    // R6
    check(unstable == 0, "R6", "tx changes between strobes", unstable, 0);
    if (lose_at < 0)
      // R9 / R10: strobe count equals 44 + 8*bytes
      check(ticks == exp_len, "R9", "strobes per frame", ticks, exp_len);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [10:0] rid;
    logic [3:0]  rd;
    logic [63:0] rdat;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; bit_tick = 1'b0; start = 1'b0; ext_bus = 1'b1;
    id_i = '0; rtr_i = 1'b0; dlc_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    // R1
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0 && arb_lost === 1'b0,
          "R1", "reset state {tx,busy,done,arb}", {28'd0, tx, busy, done, arb_lost}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: strobes while idle leave the line recessive
    bit_tick = 1'b1; ext_bus = 1'b0;
    repeat (2) @(negedge clk);
    bit_tick = 1'b0; ext_bus = 1'b1;
    check(tx === 1'b1 && busy === 1'b0, "R1", "idle under strobes", {30'd0, tx, busy}, 32'h2);

    // directed corner cases
    run_frame(11'h123, 1'b0, 4'd0, 64'h0, 1'b1, -1, 1'b0);               // R3 R4 no data
    run_frame(11'h7FF, 1'b1, 4'd8, {64{1'b1}}, 1'b1, -1, 1'b0);          // R4 all ones
    run_frame(11'h000, 1'b0, 4'd12, 64'h0123_4567_89AB_CDEF, 1'b1, -1, 1'b0); // R10
    run_frame(11'h2A5, 1'b0, 4'd2, 64'hA55A_0000_0000_0000, 1'b0, -1, 1'b0);  // R8 no ack
    run_frame(11'h7FF, 1'b0, 4'd3, 64'h1122_3300_0000_0000, 1'b1, 4, 1'b0);   // R7 in id
    run_frame(11'h400, 1'b1, 4'd1, 64'hFF00_0000_0000_0000, 1'b1, 12, 1'b0);  // R7 on rtr
    run_frame(11'h155, 1'b0, 4'd4, 64'hDEAD_BEEF_0000_0000, 1'b1, -1, 1'b1);  // R2 poke

    // constrained random frames
    for (int n = 0; n < 20; n++) begin
      rid  = 11'($urandom);
      rd   = 4'($urandom_range(0, 15));
      rdat = {$urandom, $urandom};
      run_frame(rid, 1'($urandom), rd, rdat, 1'b1, -1, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule